// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit does the interrupt bookkeeping for a peripheral that exposes sixteen byte-wide registers. It takes the register index from address bits [12:9]. Two of those indices belong to the unit. One holds the pending interrupt flags and the other holds the interrupt enables. Two internal sources raise flags with single-cycle set pulses: a shift register and a timer. The unit drives one level-sensitive interrupt line.

Software acknowledges an interrupt by writing ones to the flag register. Reading the shift data index also acknowledges the shift interrupt. The enable register is changed one bit group at a time. The top bit of the written byte selects whether the other bits that are written as 1 are set or cleared. The interrupt line is registered and looks only at the shift and timer positions.

Top module: `irq_flag_unit`

## Requirements
- R1: The register index is `addr_i[12:9]`. Reading index 13 returns the flag byte. Reading index 14 returns the enable byte with bit 7 reading 0. Reading any other index returns 0 on `rdata_o`. Address bits [8:0] do not affect decoding.
- R2: A pulse on `sr_set_i` sets flag bit 2, and a pulse on `tmr_set_i` sets flag bit 6. A flag stays set until it is cleared. No other flag bit can ever become 1.
- R3: A write to index 13 clears every flag bit whose written bit is 1. It leaves every other flag bit unchanged.
- R4: A write to index 14 with data bit 7 = 1 ORs data bits [6:0] into the enables.
- R5: A write to index 14 with data bit 7 = 0 clears every enable bit written as 1. The other enable bits keep their values.
- R6: A read of index 10 clears flag bit 2 only. Reads of any other index clear nothing.
- R7: When a set pulse and a clearing write or read hit the same flag bit in the same cycle, the flag ends up set.
- R8: `irq_o` is registered. In each cycle it equals whether (flag & enable) had bit 2 or bit 6 set in the previous cycle. Enable bits other than 2 and 6 have no effect on `irq_o`.
- R9: After reset the flags read 0x00, the enables read 0x44, and `irq_o` is 0.
- R10: Writes to indices other than 13 and 14 change neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 13 | Byte address; bits [12:9] select the register |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the flag and enable indices, else 0 |
| sr_set_i | input | 1 | Shift register event pulse |
| tmr_set_i | input | 1 | Timer event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a collision: a source pulse lands in the same cycle as the write or read that would clear that same flag. The stimulus reaches it by driving set pulses on purpose in cycles that also carry a flag write with all ones or a read of the shift data index. It also covers the opposite collision, where the other source's pulse meets a clear of this flag. A second case needs enable bits other than 2 and 6 set while the matching flags cannot exist. The bench sets enables 0x3B with the mode bit high, then checks that the line still depends only on the gated positions.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 13;
  localparam int unsigned IDX_LSB = 9;
  localparam int unsigned IDX_W   = 4;
  localparam logic [IDX_W-1:0] IDX_SHIFT = 4'd10;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_EN    = 4'd14;
  localparam int unsigned SR_BIT  = 2;
  localparam int unsigned TMR_BIT = 6;
  localparam logic [DATA_W-1:0] SRC_MASK = (DATA_W'(1) << SR_BIT) | (DATA_W'(1) << TMR_BIT);

  typedef struct packed {
    logic flag_hit;
    logic en_hit;
    logic shift_hit;
  } idx_hit_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_unit_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LSB = IDX_LSB
) (
  input  logic [AW-1:0] addr_i,
  output idx_hit_t      hit_o
);
  logic [IDX_W-1:0] idx;
  assign idx = addr_i[LSB +: IDX_W];

  always_comb begin
    hit_o.flag_hit  = (idx == IDX_FLAG);
    hit_o.en_hit    = (idx == IDX_EN);
    hit_o.shift_hit = (idx == IDX_SHIFT);
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_ff
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= 1'b0;
        else if (set_i[b])  q <= 1'b1;  // set beats clear
        else if (clr_i[b])  q <= 1'b0;
      end
      assign flag_o[b] = q;

      assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[b] |=> flag_o[b]);
      assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[b] && !set_i[b]) |=> !flag_o[b]);
      assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o[b] && !clr_i[b]) |=> flag_o[b]);
    end else begin : g_tie
      assign flag_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-2:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-2:0] en_q;
  logic         set_mode;
  assign set_mode = wdata_i[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= RST_VAL;
    else if (wr_i) begin
      if (set_mode)    en_q <= en_q | wdata_i[W-2:0];
      else             en_q <= en_q & ~wdata_i[W-2:0];
    end
  end
  assign en_o = {1'b0, en_q};

  for (genvar b = 0; b < W-1; b++) begin : g_chk
    assert_en_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wdata_i[W-1] && wdata_i[b]) |=> en_o[b]);
    assert_en_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[W-1] && wdata_i[b]) |=> !en_o[b]);
    assert_en_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(en_o[b]));
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] GATE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic pend;
  assign pend = |(flag_i & en_i & GATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= pend;
  end

  assert_irq_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> irq_o);
  assert_irq_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |=> !irq_o);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sr_set_i,
  input  logic              tmr_set_i,
  output logic              irq_o
);
  localparam logic [DATA_W-2:0] EN_RST = SRC_MASK[DATA_W-2:0];

  idx_hit_t          hit;
  logic [DATA_W-1:0] flag, en, set_vec, clr_vec;

  irq_addr_dec #(.AW(ADDR_W), .LSB(IDX_LSB)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[SR_BIT]  = sr_set_i;
    set_vec[TMR_BIT] = tmr_set_i;
    clr_vec = (wr_i && hit.flag_hit) ? wdata_i : '0;
    if (rd_i && hit.shift_hit) clr_vec[SR_BIT] = 1'b1;
  end

  irq_flag_reg #(.W(DATA_W), .IMPL_MASK(SRC_MASK)) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flag)
  );

  irq_en_reg #(.W(DATA_W), .RST_VAL(EN_RST)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i && hit.en_hit),
    .wdata_i (wdata_i),
    .en_o    (en)
  );

  irq_out_reg #(.W(DATA_W), .GATE(SRC_MASK)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag),
    .en_i   (en),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit.flag_hit)    rdata_o = flag;
    else if (hit.en_hit) rdata_o = en;
  end

  assert_flag_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag & ~SRC_MASK) == '0);
  assert_shift_read_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit.shift_hit && !sr_set_i) |=> !flag[SR_BIT]);
endmodule

// File: tb/irq_flag_unit_bench.sv
module irq_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0, sr = 1'b0, tm = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0, fails = 0;
  int m_flag, m_en, m_irq;

  always #5 clk = ~clk;

  irq_flag_unit u_irq_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sr_set_i(sr), .tmr_set_i(tm), .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rd_model(int idx);
    if (idx == 13) return m_flag;
    if (idx == 14) return m_en;
    return 0;
  endfunction

  // one cycle: drive, check read data, clock, update model, check irq
  task automatic cyc(string tag, bit w, bit r, int idx, int low, int d, bit s, bit t);
    int nirq;
    @(negedge clk);
    wr = w; rd = r; addr = 13'((idx << 9) | (low & 9'h1ff)); wdata = 8'(d); sr = s; tm = t;
    #1;
    chk({tag, " rdata R1"}, int'(rdata), rd_model(idx));
    @(posedge clk);
    nirq = ((m_flag & m_en & 8'h44) != 0) ? 1 : 0;
    if (w && idx == 13) m_flag &= ~d;
    if (r && idx == 10) m_flag &= ~4;
    if (s) m_flag |= 4;
    if (t) m_flag |= 8'h40;
    if (w && idx == 14) m_en = ((d & 8'h80) != 0) ? (m_en | (d & 8'h7f)) : (m_en & ~d & 8'h7f);
    m_irq = nirq;
    #1;
    chk({tag, " irq R8"}, int'(irq), m_irq);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_flag = 0; m_en = 8'h44; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc("R9 flag reset", 0, 0, 13, 0, 0, 0, 0);
    cyc("R9 en reset", 0, 0, 14, 0, 0, 0, 0);
    // R2 set pulses, R8 irq latency
    cyc("R2 sr pulse", 0, 0, 13, 0, 0, 1, 0);
    cyc("R2 hold", 0, 0, 13, 9'h1ff, 0, 0, 0);
    cyc("R2 tmr pulse", 0, 0, 13, 5, 0, 0, 1);
    cyc("R2 both", 0, 0, 13, 0, 0, 0, 0);
    // R3 partial clear
    cyc("R3 clear tmr", 1, 0, 13, 3, 8'h40, 0, 0);
    cyc("R3 observe", 0, 0, 13, 0, 0, 0, 0);
    // R6 read of shift data index
    cyc("R6 read other", 0, 1, 13, 0, 0, 0, 1);
    cyc("R6 read idx10", 0, 1, 10, 0, 0, 0, 0);
    cyc("R6 observe", 0, 0, 13, 0, 0, 0, 0);
    // R7 collisions
    cyc("R7 wr clr vs sr", 1, 0, 13, 0, 8'hff, 1, 0);
    cyc("R7 observe", 0, 0, 13, 0, 0, 0, 0);
    cyc("R7 rd clr vs sr", 0, 1, 10, 0, 0, 1, 0);
    cyc("R7 clr tmr vs sr", 1, 0, 13, 0, 8'h40, 1, 0);
    cyc("R7 observe2", 0, 0, 13, 0, 0, 0, 0);
    // R5 enable clear, R4 enable set
    cyc("R5 clr en2", 1, 0, 14, 0, 8'h04, 0, 0);
    cyc("R5 observe", 0, 0, 14, 0, 0, 0, 0);
    cyc("R5 clr en6", 1, 0, 14, 0, 8'h40, 0, 0);
    cyc("R8 masked", 0, 0, 14, 0, 0, 0, 0);
    cyc("R4 set others", 1, 0, 14, 0, 8'hbb, 0, 0);
    cyc("R8 ungated en", 0, 0, 14, 0, 0, 0, 0);
    cyc("R8 ungated en2", 0, 0, 13, 0, 0, 0, 0);
    cyc("R4 set en6", 1, 0, 14, 9'h0aa, 8'hc0, 0, 0);
    cyc("R4 observe", 0, 0, 14, 0, 0, 0, 0);
    cyc("R8 fire", 0, 0, 13, 0, 0, 0, 0);
    // R10 writes elsewhere
    for (int i = 0; i < 16; i++)
      if (i != 13 && i != 14) cyc("R10 other wr", 1, 0, i, i, 8'hff, 0, 0);
    cyc("R10 flag", 0, 0, 13, 0, 0, 0, 0);
    cyc("R10 en", 0, 0, 14, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 200; i++)
      cyc("R1 mix", (i % 5) == 0, (i % 7) == 0, (i % 3 == 0) ? 13 : ((i % 3 == 1) ? 14 : 10),
          i * 37, (i * 73) & 8'hff, (i % 4) == 1, (i % 6) == 2);
    cyc("R3 clear all", 1, 0, 13, 0, 8'hff, 0, 0);
    cyc("R3 done", 0, 0, 13, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule